// File: doc/BRIEF.md
# Camera Pixel Word Packer

This block sits behind a parallel camera port and runs on the pixel clock. Each clock it looks at the pixel bus and the two framing lines. A sample is taken when both framing lines are at their configured active level. The sample is masked to the selected bus width, which is 8, 10, 12 or 14 bits. Accepted samples are then packed into 32-bit words for a downstream FIFO or DMA engine.

In 8-bit mode four bytes fill a word. In the three wide modes two zero-extended 16-bit halves fill a word. When the vertical framing line turns active, the block marks the start of a frame. When that line drops, it marks the end of the frame and flushes any partly built word.

The result leaves through a valid/ready pair. If a finished word arrives while the previous one is still waiting, the new word replaces it and a sticky overflow flag is raised. Embedded synchronization may only be requested together with 8-bit mode. Any other combination raises a configuration error and captures nothing.

Top module: `cam_word_packer`

## Requirements
- R1: The width field `cfg_width` selects 8-bit (2'b00), 10-bit (2'b01), 12-bit (2'b10) or 14-bit (2'b11) capture. Pixel bits above the selected width are ignored and appear as zero in the output.
- R2: In 8-bit mode the first through fourth accepted samples of a word occupy bits [7:0], [15:8], [23:16] and [31:24] in that order.
- R3: In 10-, 12- and 14-bit modes the first sample of a pair occupies bits [15:0] and the second occupies bits [31:16]. Each half is zero above the sample width, so one word is produced for every two accepted samples.
- R4: A sample is accepted on a clock edge only when `vsync` and `hsync` are both at their active level. Samples taken while `hsync` is inactive have no effect on the packed data.
- R5: `vsync` is active when it equals `cfg_vs_pol`, and `hsync` is active when it equals `cfg_hs_pol`, so either polarity is supported.
- R6: `frame_start` pulses for one cycle after the edge at which `vsync` turns active. This edge also restarts packing at the lowest slot, and a sample accepted at that same edge goes into the lowest slot.
- R7: `frame_end` pulses for one cycle after the edge at which `vsync` turns inactive. If a word was partly filled at that point, it is emitted with its empty slots set to zero.
- R8: A new word appears with `out_valid` high in the cycle after the edge that completed it. `out_valid` and `out_data` then hold until an edge at which `out_ready` is high.
- R9: If a word completes while `out_valid` is high and `out_ready` is low, the new word replaces the old one and `overflow` sets. `overflow` stays set until reset.
- R10: When `cfg_embedded` is 1 and `cfg_width` is not 2'b00, `cfg_error` is high in the following cycle. In that state no sample is accepted, any partial word is discarded, and no word is emitted.
- R11: After reset, `out_valid`, `frame_start`, `frame_end`, `cfg_error` and `overflow` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_width | input | 2 | Bus width select |
| cfg_embedded | input | 1 | Embedded synchronization requested |
| cfg_vs_pol | input | 1 | Active level of vsync |
| cfg_hs_pol | input | 1 | Active level of hsync |
| pix_data | input | 14 | Parallel pixel bus |
| vsync | input | 1 | Frame framing line |
| hsync | input | 1 | Line framing / data-valid line |
| out_ready | input | 1 | Downstream ready |
| out_data | output | 32 | Packed word |
| out_valid | output | 1 | Packed word valid |
| frame_start | output | 1 | Frame start pulse |
| frame_end | output | 1 | Frame end pulse |
| cfg_error | output | 1 | Illegal sync/width combination |
| overflow | output | 1 | Sticky overflow flag |

## Verification
Every mode is driven with random full 14-bit pixel values. Bits above the selected width leaking into a half or a byte lane would show up here. Frame lengths that are not a multiple of the word's sample count exercise the zero-filled flush. Gaps in `hsync` separate qualified samples from unqualified ones. Inverted polarities separate active-level decoding from fixed-level decoding. A long stall of `out_ready` shows holding behaviour and then overflow. An illegal embedded-sync setting shows whether capture is really suppressed or merely flagged.

// File: rtl/cam_pack_pkg.sv
package cam_pack_pkg;

    localparam int PIX_MAX_W = 14;
    localparam int WORD_W    = 32;
    localparam int HALF_W    = WORD_W / 2;
    localparam int BYTE_W    = WORD_W / 4;
    localparam int SLOT_CNT  = WORD_W / BYTE_W;
    localparam int POS_W     = $clog2(SLOT_CNT);

    typedef enum logic [1:0] {
        PIX_8  = 2'b00,
        PIX_10 = 2'b01,
        PIX_12 = 2'b10,
        PIX_14 = 2'b11
    } pix_width_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic take;
    } frame_evt_t;

    function automatic logic [PIX_MAX_W-1:0] keep_mask(pix_width_e w);
        case (w)
            PIX_8:   keep_mask = PIX_MAX_W'(14'h00FF);
            PIX_10:  keep_mask = PIX_MAX_W'(14'h03FF);
            PIX_12:  keep_mask = PIX_MAX_W'(14'h0FFF);
            default: keep_mask = PIX_MAX_W'(14'h3FFF);
        endcase
    endfunction

    function automatic logic [POS_W-1:0] last_slot(pix_width_e w);
        last_slot = (w == PIX_8) ? POS_W'(SLOT_CNT - 1) : POS_W'(1);
    endfunction

endpackage

// File: rtl/cam_sync_frontend.sv
module cam_sync_frontend
    import cam_pack_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       vsync,
    input  logic       hsync,
    input  logic       vs_pol,
    input  logic       hs_pol,
    input  logic       block,
    output frame_evt_t evt
);
    logic vs_act;
    logic hs_act;
    logic vs_q;

    assign vs_act = (vsync == vs_pol);
    assign hs_act = (hsync == hs_pol);

    always_ff @(posedge clk) begin
        if (rst) vs_q <= 1'b0;
        else     vs_q <= vs_act;
    end

    assign evt.start = vs_act && !vs_q;
    assign evt.stop  = !vs_act && vs_q;
    assign evt.take  = vs_act && hs_act && !block;
endmodule

// File: rtl/cam_lane_packer.sv
module cam_lane_packer
    import cam_pack_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  pix_width_e           width,
    input  frame_evt_t           evt,
    input  logic                 drop,
    input  logic [PIX_MAX_W-1:0] pix,
    output logic                 word_done,
    output logic [WORD_W-1:0]    word
);
    logic [POS_W-1:0]     pos, pos_eff;
    logic [WORD_W-1:0]    acc, acc_eff, acc_new, lane;
    logic [PIX_MAX_W-1:0] sample;
    logic                 slot_last;

    assign sample    = pix & keep_mask(width);
    assign pos_eff   = evt.start ? '0 : pos;
    assign acc_eff   = evt.start ? '0 : acc;
    assign slot_last = (pos_eff == last_slot(width));

    always_comb begin
        lane = '0;
        for (int k = 0; k < SLOT_CNT; k++) begin
            if (pos_eff == POS_W'(k)) begin
                if (width == PIX_8)
                    lane = WORD_W'(sample[BYTE_W-1:0]) << (k * BYTE_W);
                else if (k < WORD_W / HALF_W)
                    lane = WORD_W'(sample) << (k * HALF_W);
            end
        end
    end

    assign acc_new   = acc_eff | lane;
    assign word_done = !drop && ((evt.take && slot_last) || (evt.stop && pos != '0));
    assign word      = evt.take ? acc_new : acc;

    always_ff @(posedge clk) begin
        if (rst || drop || evt.stop) begin
            pos <= '0;
            acc <= '0;
        end else if (evt.take) begin
            if (slot_last) begin
                pos <= '0;
                acc <= '0;
            end else begin
                pos <= pos_eff + POS_W'(1);
                acc <= acc_new;
            end
        end else if (evt.start) begin
            pos <= '0;
            acc <= '0;
        end
    end
endmodule

// File: rtl/cam_out_stage.sv
module cam_out_stage
    import cam_pack_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              word_done,
    input  logic [WORD_W-1:0] word,
    input  logic              ready,
    output logic              valid,
    output logic [WORD_W-1:0] data,
    output logic              ovf
);
    logic pending;
    assign pending = valid && !ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            data  <= '0;
            ovf   <= 1'b0;
        end else begin
            if (word_done) begin
                data  <= word;
                valid <= 1'b1;
                if (pending) ovf <= 1'b1;
            end else if (valid && ready) begin
                valid <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/cam_word_packer.sv
module cam_word_packer
    import cam_pack_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [1:0]           cfg_width,
    input  logic                 cfg_embedded,
    input  logic                 cfg_vs_pol,
    input  logic                 cfg_hs_pol,
    input  logic [PIX_MAX_W-1:0] pix_data,
    input  logic                 vsync,
    input  logic                 hsync,
    input  logic                 out_ready,
    output logic [WORD_W-1:0]    out_data,
    output logic                 out_valid,
    output logic                 frame_start,
    output logic                 frame_end,
    output logic                 cfg_error,
    output logic                 overflow
);
    pix_width_e        width;
    frame_evt_t        evt;
    logic              illegal;
    logic              word_done;
    logic [WORD_W-1:0] word;

    assign width   = pix_width_e'(cfg_width);
    assign illegal = cfg_embedded && (width != PIX_8);

    cam_sync_frontend u_sync (
        .clk    (clk),
        .rst    (rst),
        .vsync  (vsync),
        .hsync  (hsync),
        .vs_pol (cfg_vs_pol),
        .hs_pol (cfg_hs_pol),
        .block  (illegal),
        .evt    (evt)
    );

    cam_lane_packer u_pack (
        .clk       (clk),
        .rst       (rst),
        .width     (width),
        .evt       (evt),
        .drop      (illegal),
        .pix       (pix_data),
        .word_done (word_done),
        .word      (word)
    );

    cam_out_stage u_out (
        .clk       (clk),
        .rst       (rst),
        .word_done (word_done),
        .word      (word),
        .ready     (out_ready),
        .valid     (out_valid),
        .data      (out_data),
        .ovf       (overflow)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_start <= 1'b0;
            frame_end   <= 1'b0;
            cfg_error   <= 1'b0;
        end else begin
            frame_start <= evt.start;
            frame_end   <= evt.stop;
            cfg_error   <= illegal;
        end
    end
endmodule

// File: rtl/cam_word_packer_chk.sv
module cam_word_packer_chk (
    input logic        clk,
    input logic        rst,
    input logic        out_ready,
    input logic [31:0] out_data,
    input logic        out_valid,
    input logic        frame_start,
    input logic        frame_end,
    input logic        overflow
);
    AST_VALID_HOLD: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid); // R8
    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready && !overflow |=> $stable(out_data) || overflow); // R8
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow); // R9
    AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> !frame_start); // R6
    AST_END_PULSE: assert property (@(posedge clk) disable iff (rst)
        frame_end |=> !frame_end); // R7
    AST_START_END_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(frame_start && frame_end)); // R6
endmodule

bind cam_word_packer cam_word_packer_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .out_ready   (out_ready),
    .out_data    (out_data),
    .out_valid   (out_valid),
    .frame_start (frame_start),
    .frame_end   (frame_end),
    .overflow    (overflow)
);

// File: tb/cam_word_packer_tb.sv
module cam_word_packer_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  cfg_width = 2'b00;
    logic        cfg_embedded = 1'b0;
    logic        cfg_vs_pol = 1'b1;
    logic        cfg_hs_pol = 1'b1;
    logic [13:0] pix_data = '0;
    logic        vsync = 1'b0;
    logic        hsync = 1'b0;
    logic        out_ready = 1'b1;
    logic [31:0] out_data;
    logic        out_valid, frame_start, frame_end, cfg_error, overflow;

    always #10 clk = ~clk;

    cam_word_packer dut_i (
        .clk(clk), .rst(rst), .cfg_width(cfg_width), .cfg_embedded(cfg_embedded),
        .cfg_vs_pol(cfg_vs_pol), .cfg_hs_pol(cfg_hs_pol), .pix_data(pix_data),
        .vsync(vsync), .hsync(hsync), .out_ready(out_ready), .out_data(out_data),
        .out_valid(out_valid), .frame_start(frame_start), .frame_end(frame_end),
        .cfg_error(cfg_error), .overflow(overflow)
    );

    int    n_checks = 0;
    int    n_fail = 0;
    string tag = "R11 reset";

    // behavioural reference
    int unsigned q[$];
    bit          m_prev_vs = 0;
    bit          e_valid = 0, e_fs = 0, e_fe = 0, e_err = 0, e_ovf = 0;
    bit [31:0]   e_data = 0;

    function automatic bit [31:0] build(int unsigned s[$], int slot_bits);
        bit [31:0] w = 0;
        foreach (s[i]) w = w | (32'(s[i]) << (i * slot_bits));
        return w;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            q.delete(); m_prev_vs = 0;
            e_valid = 0; e_fs = 0; e_fe = 0; e_err = 0; e_ovf = 0; e_data = 0;
        end else begin
            bit vs_a, hs_a, bad, have, pend;
            bit [31:0] w;
            int bits, per, slot_bits;
            bits = (cfg_width == 2'b00) ? 8 : (cfg_width == 2'b01) ? 10 :
                   (cfg_width == 2'b10) ? 12 : 14;
            per = (cfg_width == 2'b00) ? 4 : 2;
            slot_bits = (cfg_width == 2'b00) ? 8 : 16;
            vs_a = (vsync == cfg_vs_pol);
            hs_a = (hsync == cfg_hs_pol);
            bad  = cfg_embedded && (cfg_width != 2'b00);
            have = 0; w = 0;
            e_fs = vs_a && !m_prev_vs;
            e_fe = !vs_a && m_prev_vs;
            m_prev_vs = vs_a;
            if (bad) q.delete();
            else begin
                if (e_fs) q.delete();
                if (e_fe && q.size() > 0) begin
                    w = build(q, slot_bits); have = 1; q.delete();
                end
                if (vs_a && hs_a) begin
                    q.push_back(int'(pix_data) % (1 << bits));
                    if (q.size() == per) begin
                        w = build(q, slot_bits); have = 1; q.delete();
                    end
                end
            end
            pend = e_valid && !out_ready;
            if (have) begin
                e_data = w; e_valid = 1;
                if (pend) e_ovf = 1;
            end else if (e_valid && out_ready) e_valid = 0;
            e_err = bad;
        end
    end

    task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: %s actual %h expected %h", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        chk("out_valid", 32'(out_valid), 32'(e_valid));
        if (e_valid) chk("out_data", out_data, e_data);
        chk("frame_start", 32'(frame_start), 32'(e_fs));
        chk("frame_end", 32'(frame_end), 32'(e_fe));
        chk("cfg_error", 32'(cfg_error), 32'(e_err));
        chk("overflow", 32'(overflow), 32'(e_ovf));
    end

    task automatic frame(int n, int gap, bit rnd_ready);
        @(negedge clk);
        vsync = cfg_vs_pol;
        for (int i = 0; i < n; i++) begin
            pix_data = 14'($urandom);
            hsync = (gap != 0 && (i % gap) == gap - 1) ? !cfg_hs_pol : cfg_hs_pol;
            if (rnd_ready) out_ready = ($urandom % 4) != 0;
            @(negedge clk);
        end
        hsync = !cfg_hs_pol;
        vsync = !cfg_vs_pol;
        out_ready = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    int  cyc = 0;
    bit  done = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: cycles actual %0d expected below 100000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        vsync = 1'b0; hsync = 1'b0;
        repeat (2) @(negedge clk);
        tag = "R2 R7 8-bit with flush";
        cfg_width = 2'b00; frame(10, 0, 0);
        tag = "R1 R3 10-bit";
        cfg_width = 2'b01; frame(9, 0, 1);
        tag = "R1 R3 12-bit";
        cfg_width = 2'b10; frame(12, 0, 1);
        tag = "R1 R3 R7 14-bit odd length";
        cfg_width = 2'b11; frame(7, 0, 0);
        tag = "R4 hsync gaps";
        cfg_width = 2'b00; frame(20, 3, 0);
        cfg_width = 2'b10; frame(15, 4, 0);
        tag = "R5 inverted polarity";
        cfg_vs_pol = 1'b0; cfg_hs_pol = 1'b0;
        vsync = 1'b1; hsync = 1'b1;
        repeat (2) @(negedge clk);
        cfg_width = 2'b11; frame(11, 5, 0);
        cfg_width = 2'b00; frame(13, 0, 0);
        cfg_vs_pol = 1'b1; cfg_hs_pol = 1'b1;
        vsync = 1'b0; hsync = 1'b0;
        repeat (2) @(negedge clk);
        tag = "R6 back-to-back frames";
        cfg_width = 2'b00;
        @(negedge clk); vsync = 1'b1; hsync = 1'b1;
        repeat (3) begin pix_data = 14'($urandom); @(negedge clk); end
        vsync = 1'b0; @(negedge clk);
        vsync = 1'b1;
        repeat (5) begin pix_data = 14'($urandom); @(negedge clk); end
        vsync = 1'b0; hsync = 1'b0; repeat (3) @(negedge clk);
        tag = "R10 illegal embedded";
        cfg_embedded = 1'b1; cfg_width = 2'b10;
        frame(8, 0, 0);
        tag = "R10 legal embedded 8-bit";
        cfg_width = 2'b00; frame(8, 0, 0);
        cfg_embedded = 1'b0;
        tag = "R8 R9 stalled output";
        cfg_width = 2'b01;
        @(negedge clk); out_ready = 1'b0; vsync = 1'b1; hsync = 1'b1;
        repeat (8) begin pix_data = 14'($urandom); @(negedge clk); end
        vsync = 1'b0; hsync = 1'b0;
        repeat (3) @(negedge clk);
        out_ready = 1'b1;
        repeat (3) @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule